// File: doc/BRIEF.md
# Delay-Slot-Aware Exception Capture Unit

This unit runs beside a simple in-order pipeline that executes exactly one delay-slot instruction after every branch or jump. Each cycle the pipeline presents at most one completing instruction. The unit tracks whether that instruction sits in the delay slot of the transfer before it. When the instruction faults, the unit records where the handler must later resume. It fills a status word with the exception code and a delay-slot marker, and it steers fetch to a fixed handler entry point in the same cycle.

A faulting delay-slot instruction cannot simply be restarted, because its branch would then be lost. In that case the unit records the address of the branch itself, which is four bytes lower, and sets the marker so the handler knows the branch will run again. A return request steers fetch back to the saved address. A second control transfer placed inside a delay slot is treated as a reserved instruction and is not honoured.

The completion input is a plain per-cycle strobe with no back-pressure: the unit never stalls the pipeline, so it has no ready signal. The redirect output is a strobe that fetch must obey in the cycle it is high.

Top module: `dslot_exc_unit`

## Requirements
- R1: After reset the saved address and the status word are zero, no redirect is driven, and the first instruction is not treated as a delay-slot instruction.
- R2: An exception on an instruction outside a delay slot saves that instruction's address and clears status bit 31.
- R3: An exception on the instruction right after a control transfer saves the address minus 4 and sets status bit 31.
- R4: Only the single valid instruction after a control transfer counts as in the slot. The one after it is treated as an ordinary instruction.
- R5: The status word holds the delay-slot marker in bit 31 and the 5-bit exception code in bits 6:2. All other bits are zero. Code 9 (breakpoint) is stored like any other code.
- R6: An exception drives the redirect strobe high in the same cycle, with target 0x8000_0180.
- R7: A control transfer arriving while in the slot raises code 10 with the delay-slot marker set. The transfer is not honoured, so the following instruction is not in a slot.
- R8: A return request drives the redirect strobe with the saved address as target. It leaves the saved address and the status word unchanged, and it clears the in-slot state.
- R9: When an exception and a return request arrive in the same cycle, the exception wins.
- R10: An exception request without a valid instruction is ignored. Cycles with no valid instruction do not advance the in-slot state.
- R11: Taking an exception clears the in-slot state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | An instruction completes this cycle |
| ins_pc | input | 32 | Address of the completing instruction |
| ins_is_ct | input | 1 | Completing instruction is a branch or jump |
| exc_req | input | 1 | Completing instruction faults |
| exc_code | input | 5 | Exception code of the fault |
| eret_req | input | 1 | Return from the handler |
| redir_valid | output | 1 | Fetch must redirect this cycle |
| redir_target | output | 32 | Redirect address |
| epc | output | 32 | Saved resume address |
| cause | output | 32 | Status word: marker and code |

## Verification
The bench faults the delay-slot instruction, with and without idle cycles between it and its branch. A design that counts raw cycles instead of valid instructions, or that ignores the slot, would save the faulting address with the marker clear. It faults the instruction two after a branch, which catches a slot flag that lingers. It places a jump in a slot, where a broken design would honour it and mark the next instruction as in-slot. It also sends a return together with a fault, where a design with the wrong priority would jump to the saved address. Finally, it checks that a return clears a pending slot, so that a later fault is not mislabelled.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned CODE_W     = 5;
  localparam int unsigned CODE_LSB   = 2;
  localparam int unsigned INSTR_STEP = 4;
  localparam logic [CODE_W-1:0] CODE_RESERVED = 5'd10;
  localparam logic [CODE_W-1:0] CODE_BREAK    = 5'd9;
  localparam logic [XLEN-1:0]   HANDLER_VEC   = 32'h8000_0180;
endpackage

// File: rtl/dslot_tracker.sv
module dslot_tracker
  import dslot_pkg::*;
#(
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic          ins_is_ct,
  input  logic          exc_req,
  input  logic [CW-1:0] exc_code,
  input  logic          eret_req,
  output logic          in_slot,
  output logic          exc_take,
  output logic [CW-1:0] take_code
);
  logic illegal_ct;

  assign illegal_ct = ins_valid && ins_is_ct && in_slot;
  assign exc_take   = ins_valid && (exc_req || illegal_ct);
  assign take_code  = exc_req ? exc_code : CW'(CODE_RESERVED);

  always_ff @(posedge clk) begin
    if (!rst_n)                   in_slot <= 1'b0;
    else if (exc_take || eret_req) in_slot <= 1'b0;
    else if (ins_valid)            in_slot <= ins_is_ct;
  end

  AST_SLOT_ONE_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot && ins_valid) |=> !in_slot); // R4
  AST_SLOT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_valid && !eret_req) |=> in_slot == $past(in_slot)); // R10
  AST_RET_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    eret_req |=> !in_slot); // R8
  AST_EXC_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> !in_slot); // R11
endmodule

// File: rtl/dslot_capture.sv
module dslot_capture
  import dslot_pkg::*;
#(
  parameter int unsigned AW   = XLEN,
  parameter int unsigned CW   = CODE_W,
  parameter int unsigned STEP = INSTR_STEP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_take,
  input  logic          take_bd,
  input  logic [CW-1:0] take_code,
  input  logic [AW-1:0] ins_pc,
  input  logic          eret_req,
  output logic [AW-1:0] epc,
  output logic [AW-1:0] cause
);
  localparam int unsigned BD_BIT = AW - 1;
  localparam logic [AW-1:0] FIELD_MASK =
    (AW'(1) << BD_BIT) | (((AW'(1) << CW) - AW'(1)) << CODE_LSB);

  logic [AW-1:0] cause_next;

  always_comb begin
    cause_next = '0;
    cause_next[BD_BIT] = take_bd;
    cause_next[CODE_LSB +: CW] = take_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= '0;
    end else if (exc_take) begin
      epc   <= take_bd ? (ins_pc - AW'(STEP)) : ins_pc;
      cause <= cause_next;
    end
  end

  AST_CAUSE_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cause & ~FIELD_MASK) == '0); // R5
  AST_BD_TRACKS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> cause[BD_BIT] == $past(take_bd)); // R3
  AST_RET_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_req && !exc_take) |=> ($stable(epc) && $stable(cause))); // R8
endmodule

// File: rtl/dslot_redirect.sv
module dslot_redirect
  import dslot_pkg::*;
#(
  parameter int unsigned AW = XLEN,
  parameter logic [AW-1:0] VEC = HANDLER_VEC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_take,
  input  logic          eret_req,
  input  logic [AW-1:0] epc,
  output logic          redir_valid,
  output logic [AW-1:0] redir_target
);
  assign redir_valid  = exc_take || eret_req;
  assign redir_target = exc_take ? VEC : epc;

  AST_EXC_TO_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && eret_req) |-> (redir_valid && redir_target == VEC)); // R9
  AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_take && !eret_req) |-> !redir_valid); // R10
endmodule

// File: rtl/dslot_exc_unit.sv
module dslot_exc_unit
  import dslot_pkg::*;
#(
  parameter int unsigned AW = XLEN,
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_pc,
  input  logic          ins_is_ct,
  input  logic          exc_req,
  input  logic [CW-1:0] exc_code,
  input  logic          eret_req,
  output logic          redir_valid,
  output logic [AW-1:0] redir_target,
  output logic [AW-1:0] epc,
  output logic [AW-1:0] cause
);
  logic          in_slot;
  logic          exc_take;
  logic [CW-1:0] take_code;

  dslot_tracker #(.CW(CW)) u_track (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_is_ct(ins_is_ct),
    .exc_req(exc_req), .exc_code(exc_code), .eret_req(eret_req),
    .in_slot(in_slot), .exc_take(exc_take), .take_code(take_code)
  );

  dslot_capture #(.AW(AW), .CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .take_bd(in_slot),
    .take_code(take_code), .ins_pc(ins_pc), .eret_req(eret_req),
    .epc(epc), .cause(cause)
  );

  dslot_redirect #(.AW(AW), .VEC(AW'(HANDLER_VEC))) u_redir (
    .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .eret_req(eret_req),
    .epc(epc), .redir_valid(redir_valid), .redir_target(redir_target)
  );

  AST_SLOT_EPC_IS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && in_slot) |=> epc == $past(ins_pc) - AW'(INSTR_STEP)); // R3
  AST_PLAIN_EPC_IS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !in_slot) |=> epc == $past(ins_pc)); // R2
endmodule

// File: tb/dslot_exc_unit_tb.sv
module dslot_exc_unit_tb;
  localparam time CLK_PERIOD = 10;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic [31:0] ins_pc = '0;
  logic        ins_is_ct = 1'b0;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic        eret_req = 1'b0;
  logic        redir_valid;
  logic [31:0] redir_target;
  logic [31:0] epc;
  logic [31:0] cause;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dslot_exc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_pc(ins_pc),
    .ins_is_ct(ins_is_ct), .exc_req(exc_req), .exc_code(exc_code),
    .eret_req(eret_req), .redir_valid(redir_valid),
    .redir_target(redir_target), .epc(epc), .cause(cause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle; check the combinational redirect before the edge.
  task automatic step(input bit v, input logic [31:0] pc, input bit ct,
                      input bit ex, input logic [4:0] code, input bit ret,
                      input string req, input bit exp_rv, input logic [31:0] exp_tgt);
    @(negedge clk);
    ins_valid = v; ins_pc = pc; ins_is_ct = ct;
    exc_req = ex; exc_code = code; eret_req = ret;
    #1;
    check(req, 32'(redir_valid), 32'(exp_rv));
    if (exp_rv) check(req, redir_target, exp_tgt);
    @(posedge clk); #1;
    ins_valid = 0; ins_is_ct = 0; exc_req = 0; eret_req = 0;
  endtask

  task automatic t_reset();
    check("R1 epc", epc, 32'h0);
    check("R1 cause", cause, 32'h0);
    check("R1 redir", 32'(redir_valid), 32'h0);
  endtask

  task automatic t_plain_break();
    step(1, 32'h1000, 0, 1, 5'd9, 0, "R6 R1", 1, VEC);
    check("R2 epc", epc, 32'h1000);
    check("R5 R1 cause", cause, 32'h0000_0024);
  endtask

  task automatic t_slot_fault();
    step(1, 32'h2000, 1, 0, 0, 0, "R4 branch", 0, 0);
    step(1, 32'h2004, 0, 1, 5'd4, 0, "R6 slot", 1, VEC);
    check("R3 epc", epc, 32'h2000);
    check("R3 R5 cause", cause, 32'h8000_0010);
  endtask

  task automatic t_after_slot();
    step(1, 32'h3000, 1, 0, 0, 0, "R4 branch", 0, 0);
    step(1, 32'h3004, 0, 0, 0, 0, "R4 slot", 0, 0);
    step(1, 32'h3008, 0, 1, 5'd12, 0, "R4 after", 1, VEC);
    check("R4 epc", epc, 32'h3008);
    check("R4 cause", cause, 32'h0000_0030);
  endtask

  task automatic t_bubbles();
    step(1, 32'h4000, 1, 0, 0, 0, "R10 branch", 0, 0);
    step(0, 32'h4444, 0, 1, 5'd7, 0, "R10 idle req", 0, 0);
    check("R10 epc kept", epc, 32'h3008);
    step(0, 32'h0, 0, 0, 0, 0, "R10 idle", 0, 0);
    step(1, 32'h4004, 0, 1, 5'd5, 0, "R10 slot", 1, VEC);
    check("R10 R3 epc", epc, 32'h4000);
    check("R10 R3 cause", cause, 32'h8000_0014);
  endtask

  task automatic t_ct_in_slot();
    step(1, 32'h5000, 1, 0, 0, 0, "R7 branch", 0, 0);
    step(1, 32'h5004, 1, 0, 0, 0, "R7 ct in slot", 1, VEC);
    check("R7 epc", epc, 32'h5000);
    check("R7 cause", cause, 32'h8000_0028);
    step(1, 32'h6000, 0, 1, 5'd7, 0, "R11 R7 next", 1, VEC);
    check("R11 R7 epc", epc, 32'h6000);
    check("R11 R7 cause", cause, 32'h0000_001C);
  endtask

  task automatic t_eret();
    step(0, 32'h0, 0, 0, 0, 1, "R8 target", 1, 32'h6000);
    check("R8 epc kept", epc, 32'h6000);
    check("R8 cause kept", cause, 32'h0000_001C);
    step(1, 32'h7000, 1, 0, 0, 1, "R8 ret+branch", 1, 32'h6000);
    step(1, 32'h7004, 0, 1, 5'd3, 0, "R8 after ret", 1, VEC);
    check("R8 slot cleared epc", epc, 32'h7004);
    check("R8 slot cleared cause", cause, 32'h0000_000C);
  endtask

  task automatic t_priority();
    step(1, 32'h8000, 0, 1, 5'd6, 1, "R9 exc wins", 1, VEC);
    check("R9 epc", epc, 32'h8000);
    check("R9 cause", cause, 32'h0000_0018);
  endtask

  task automatic t_exc_clears();
    step(1, 32'h9000, 1, 0, 0, 0, "R11 branch", 0, 0);
    step(1, 32'h9004, 0, 1, 5'd1, 0, "R11 slot", 1, VEC);
    check("R11 bd set", cause, 32'h8000_0004);
    step(1, 32'h9100, 0, 1, 5'd2, 0, "R11 next", 1, VEC);
    check("R11 epc", epc, 32'h9100);
    check("R11 cause", cause, 32'h0000_0008);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_plain_break();
    t_slot_fault();
    t_after_slot();
    t_bubbles();
    t_ct_in_slot();
    t_eret();
    t_priority();
    t_exc_clears();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule